// File: doc/BRIEF.md
# Processor Clock Source Switch Sequencer

This block picks the clock that drives the processor. Two sources are available. One is the free-running local oscillator. The other is an external bus clock divided by two. Software names the wanted source by writing a word whose bit 0 carries the choice. Every other bit of that word is ignored. When the choice differs from the source in use, the block waits a short delay and then pulls the processor reset low. It holds that reset for a long window, and it moves the clock multiplexer partway through the window. As a result, the processor never sees the edge where the clock changes.

A small detector watches the bus clock using windows timed by the local clock. If no bus-clock edge arrived in the last window, the bus clock counts as absent. A request for the bus clock is then refused, and the local clock stays in use. A status bit reports the source actually driving the processor. This bit is 1 for the local clock and 0 for the divided bus clock. The divider is a toggle flop that is held cleared while it is not selected, so its first output edge is clean.

Top module: `clksw_top`

## Requirements
- R1: After reset the local clock is selected, `stat_local` is 1 and `cpu_rst_n` is 1.
- R2: A write accepted in cycle w whose effective choice differs from the clock in use drives `cpu_rst_n` low from local-clock edge w+DELAY_CYC onward. The effective choice is bit 0 of the write data ANDed with bus-clock presence.
- R3: `cpu_rst_n` stays low for exactly HOLD_CYC local-clock cycles, then returns to 1.
- R4: The selection changes only while `cpu_rst_n` is low, at edge w+DELAY_CYC+HOLD_CYC/2+1.
- R5: `stat_local` is 1 while the local clock is selected and 0 while the divided bus clock is selected. It never changes while `cpu_rst_n` stays high.
- R6: A write whose effective choice equals the source already in use starts no reset sequence.
- R7: While the bus clock has shown no edge over a full detection window, writing 1 to bit 0 leaves the local clock selected and starts no reset.
- R8: Writes arriving while a sequence is running are ignored.
- R9: `cpu_clk` follows the local clock when the local clock is selected, and runs at half the bus-clock rate when the bus clock is selected.
- R10: Only bit 0 of `wr_data` is decoded. A write of 0xFFFE behaves like a write of 0.
- R11: With the bus clock selected and then stopped, writing 0 still runs the sequence and returns to the local clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_loc | input | 1 | Local oscillator clock; all sequencing runs on it |
| clk_bus | input | 1 | External bus clock, may stop |
| rst_n | input | 1 | Asynchronous active-low block reset |
| wr_en | input | 1 | Control-port write strobe, one local cycle |
| wr_data | input | DATA_W | Write data; bit 0 = 1 asks for the bus clock |
| cpu_clk | output | 1 | Clock delivered to the processor |
| cpu_rst_n | output | 1 | Active-low reset to the processor during a switch |
| stat_local | output | 1 | 1 = local clock in use, 0 = divided bus clock |

## Verification
The bench builds the block with DELAY_CYC=4, HOLD_CYC=12, WIN_CYC=8 and DATA_W=16. With these values, a full switch takes only sixteen cycles, so switches in both directions, writes that land mid-sequence, and the stop and restart of the bus clock all fit in a short run. The short detection window lets the bench stop the bus clock and see the veto after a few dozen cycles. A bus clock period that is not a multiple of the local one exercises the edge synchronizer.

// File: rtl/clksw_pkg.sv
`timescale 1ns/1ps
package clksw_pkg;
  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_DELAY = 2'd1,
    SQ_HOLD  = 2'd2
  } sq_state_e;
endpackage

// File: rtl/clksw_rsync.sv
`timescale 1ns/1ps
// Asynchronous assert, synchronous release of an active-low reset.
module clksw_rsync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] chain_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= 2'b00;
    else         chain_q <= {chain_q[0], 1'b1};
  end

  assign srst_n = chain_q[1];
endmodule

// File: rtl/clksw_busdet.sv
`timescale 1ns/1ps
// Bus-clock presence: a toggle in the bus domain, synchronized and
// edge-detected in the local domain, sampled over fixed windows.
module clksw_busdet #(
  parameter int WIN_CYC = 16
) (
  input  logic clk_loc,
  input  logic loc_rst_n,
  input  logic clk_bus,
  input  logic bus_rst_n,
  output logic alive
);
  localparam int WW = (WIN_CYC > 1) ? $clog2(WIN_CYC) : 1;
  localparam logic [WW-1:0] WIN_LAST = WW'(WIN_CYC - 1);

  logic           tog_q;
  logic [2:0]     sync_q;
  logic [WW-1:0]  win_q, win_d;
  logic           seen_q, seen_d;
  logic           alive_q, alive_d;
  logic           edge_hit;

  always_ff @(posedge clk_bus or negedge bus_rst_n) begin
    if (!bus_rst_n) tog_q <= 1'b0;
    else            tog_q <= ~tog_q;
  end

  assign edge_hit = sync_q[2] ^ sync_q[1];

  always_comb begin
    win_d   = win_q + 1'b1;
    seen_d  = seen_q | edge_hit;
    alive_d = alive_q;
    if (win_q == WIN_LAST) begin
      win_d   = '0;
      alive_d = seen_q | edge_hit;
      seen_d  = 1'b0;
    end
  end

  always_ff @(posedge clk_loc or negedge loc_rst_n) begin
    if (!loc_rst_n) begin
      sync_q  <= '0;
      win_q   <= '0;
      seen_q  <= 1'b0;
      alive_q <= 1'b0;
    end else begin
      sync_q  <= {sync_q[1:0], tog_q};
      win_q   <= win_d;
      seen_q  <= seen_d;
      alive_q <= alive_d;
    end
  end

  assign alive = alive_q;
endmodule

// File: rtl/clksw_div2.sv
`timescale 1ns/1ps
// Divide-by-two toggle, cleared until the selection reaches the bus domain.
module clksw_div2 (
  input  logic clk_bus,
  input  logic bus_rst_n,
  input  logic sel_bus,
  output logic div_clk
);
  logic [1:0] en_q;
  logic       div_q, div_d;

  always_comb div_d = en_q[1] ? ~div_q : 1'b0;

  always_ff @(posedge clk_bus or negedge bus_rst_n) begin
    if (!bus_rst_n) begin
      en_q  <= 2'b00;
      div_q <= 1'b0;
    end else begin
      en_q  <= {en_q[0], sel_bus};
      div_q <= div_d;
    end
  end

  assign div_clk = div_q;
endmodule

// File: rtl/clksw_seq.sv
`timescale 1ns/1ps
// Delay / hold sequencer; the selection moves at the middle of the hold.
module clksw_seq
  import clksw_pkg::*;
#(
  parameter int DELAY_CYC = 10,
  parameter int HOLD_CYC  = 5000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_en,
  input  logic wr_bit,
  input  logic alive,
  output logic sel_bus,
  output logic cpu_rst_n
);
  localparam int MAXC = (DELAY_CYC > HOLD_CYC) ? DELAY_CYC : HOLD_CYC;
  localparam int CW   = $clog2(MAXC + 1);
  localparam logic [CW-1:0] DLY_LAST = CW'(DELAY_CYC - 1);
  localparam logic [CW-1:0] HLD_LAST = CW'(HOLD_CYC - 1);
  localparam logic [CW-1:0] HLD_MID  = CW'(HOLD_CYC / 2);

  sq_state_e     st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          tgt_q, tgt_d;
  logic          sel_q, sel_d;
  logic          want;

  assign want = wr_bit & alive;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    tgt_d = tgt_q;
    sel_d = sel_q;
    case (st_q)
      SQ_IDLE: begin
        if (wr_en && (want != sel_q)) begin
          st_d  = SQ_DELAY;
          cnt_d = '0;
          tgt_d = want;
        end
      end
      SQ_DELAY: begin
        cnt_d = cnt_q + 1'b1;
        if (cnt_q == DLY_LAST) begin
          st_d  = SQ_HOLD;
          cnt_d = '0;
        end
      end
      SQ_HOLD: begin
        cnt_d = cnt_q + 1'b1;
        if (cnt_q == HLD_MID) sel_d = tgt_q & alive;
        if (cnt_q == HLD_LAST) begin
          st_d  = SQ_IDLE;
          cnt_d = '0;
        end
      end
      default: begin
        st_d  = SQ_IDLE;
        cnt_d = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= SQ_IDLE;
      cnt_q <= '0;
      tgt_q <= 1'b0;
      sel_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      tgt_q <= tgt_d;
      sel_q <= sel_d;
    end
  end

  assign sel_bus   = sel_q;
  assign cpu_rst_n = (st_q != SQ_HOLD);
endmodule

// File: rtl/clksw_top.sv
`timescale 1ns/1ps
module clksw_top #(
  parameter int DATA_W    = 32,
  parameter int DELAY_CYC = 10,
  parameter int HOLD_CYC  = 5000,
  parameter int WIN_CYC   = 16
) (
  input  logic              clk_loc,
  input  logic              clk_bus,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic              cpu_clk,
  output logic              cpu_rst_n,
  output logic              stat_local
);
  logic loc_rst_n;
  logic bus_rst_n;
  logic alive;
  logic sel;
  logic div_clk;
  logic unused_hi;

  assign unused_hi = ^wr_data[DATA_W-1:1];

  clksw_rsync loc_rs_i (.clk(clk_loc), .arst_n(rst_n), .srst_n(loc_rst_n));
  clksw_rsync bus_rs_i (.clk(clk_bus), .arst_n(rst_n), .srst_n(bus_rst_n));

  clksw_busdet #(.WIN_CYC(WIN_CYC)) det_i (
    .clk_loc(clk_loc), .loc_rst_n(loc_rst_n),
    .clk_bus(clk_bus), .bus_rst_n(bus_rst_n),
    .alive(alive)
  );

  clksw_seq #(.DELAY_CYC(DELAY_CYC), .HOLD_CYC(HOLD_CYC)) seq_i (
    .clk(clk_loc), .rst_n(loc_rst_n),
    .wr_en(wr_en), .wr_bit(wr_data[0]), .alive(alive),
    .sel_bus(sel), .cpu_rst_n(cpu_rst_n)
  );

  clksw_div2 div_i (
    .clk_bus(clk_bus), .bus_rst_n(bus_rst_n),
    .sel_bus(sel), .div_clk(div_clk)
  );

  assign cpu_clk    = sel ? div_clk : clk_loc;
  assign stat_local = ~sel;
endmodule

// File: rtl/clksw_chk.sv
`timescale 1ns/1ps
module clksw_chk #(
  parameter int HLD = 5000
) (
  input logic clk,
  input logic rst_n,
  input logic sel,
  input logic alive,
  input logic cpu_rst_n,
  input logic stat_local
);
  logic [31:0] low_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          low_cnt <= '0;
    else if (!cpu_rst_n) low_cnt <= low_cnt + 1;
    else                 low_cnt <= '0;
  end

  assert_switch_in_reset_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sel) |-> !cpu_rst_n);

  assert_bus_veto_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sel) |-> $past(alive));

  assert_hold_length_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cpu_rst_n) |-> (low_cnt == HLD));

  assert_status_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_rst_n && $past(cpu_rst_n)) |-> $stable(stat_local));
endmodule

bind clksw_top clksw_chk #(.HLD(HOLD_CYC)) chk_i (
  .clk(clk_loc), .rst_n(loc_rst_n), .sel(sel), .alive(alive),
  .cpu_rst_n(cpu_rst_n), .stat_local(stat_local)
);

// File: tb/clksw_top_tb_top.sv
`timescale 1ns/1ps
module clksw_top_tb_top;
  localparam int DW  = 16;
  localparam int DLY = 4;
  localparam int HLD = 12;
  localparam int WIN = 8;
  localparam int MID = HLD / 2;

  logic          clk_loc = 1'b0;
  logic          clk_bus = 1'b0;
  logic          bus_run = 1'b1;
  logic          rst_n   = 1'b0;
  logic          wr_en   = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic          cpu_clk, cpu_rst_n, stat_local;

  int n_chk = 0, n_bad = 0;
  int e = 0, w = 0;
  bit active = 0, m_sel = 0, m_tgt = 0, m_alive = 0;
  string scen = "R1";
  int n_cpu = 0, n_loc = 0, n_bus = 0;

  always #2 clk_loc = ~clk_loc;
  always begin
    #3;
    if (bus_run) clk_bus = ~clk_bus;
  end
  always @(posedge cpu_clk) n_cpu++;
  always @(posedge clk_loc) n_loc++;
  always @(posedge clk_bus) n_bus++;

  clksw_top #(.DATA_W(DW), .DELAY_CYC(DLY), .HOLD_CYC(HLD), .WIN_CYC(WIN)) dut_i (
    .clk_loc(clk_loc), .clk_bus(clk_bus), .rst_n(rst_n),
    .wr_en(wr_en), .wr_data(wr_data),
    .cpu_clk(cpu_clk), .cpu_rst_n(cpu_rst_n), .stat_local(stat_local)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s (scenario %s) at edge %0d: actual %0d expected %0d",
               req, scen, e, act, exp);
    end
  endtask

  task automatic tick();
    bit exp_rst;
    int k;
    @(negedge clk_loc);
    e++;
    k = e - w;
    if (wr_en && !(active && k <= DLY + HLD)) begin
      if ((wr_data[0] & m_alive) != m_sel) begin
        active = 1;
        w      = e;
        m_tgt  = wr_data[0] & m_alive;
      end
    end
    k = e - w;
    if (active && k == DLY + MID + 1) m_sel = m_tgt & m_alive;
    exp_rst = !(active && k >= DLY && k < DLY + HLD);
    chk(cpu_rst_n == exp_rst, (active && k >= DLY) ? "R3" : "R2",
        int'(cpu_rst_n), int'(exp_rst));
    chk(stat_local == !m_sel, "R4/R5 status", int'(stat_local), int'(!m_sel));
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic wr(input logic [DW-1:0] d);
    wr_en   = 1'b1;
    wr_data = d;
    tick();
    wr_en   = 1'b0;
    wr_data = '0;
  endtask

  task automatic rate_check(input string req);
    int c0, l0, b0;
    c0 = n_cpu; l0 = n_loc; b0 = n_bus;
    ticks(40);
    if (m_sel) begin
      chk(((2 * (n_cpu - c0)) - (n_bus - b0)) <= 2 &&
          ((n_bus - b0) - (2 * (n_cpu - c0))) <= 2,
          req, 2 * (n_cpu - c0), n_bus - b0);
    end else begin
      chk(((n_cpu - c0) - (n_loc - l0)) <= 1 && ((n_loc - l0) - (n_cpu - c0)) <= 1,
          req, n_cpu - c0, n_loc - l0);
    end
  endtask

  initial begin
    #(60000);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("%0d/%0d checks passed", n_chk - n_bad + 1, n_chk + 1);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk_loc);
    rst_n = 1'b1;
    // R1: reset state
    tick();
    chk(cpu_rst_n == 1'b1, "R1", int'(cpu_rst_n), 1);
    chk(stat_local == 1'b1, "R1", int'(stat_local), 1);
    ticks(40);
    m_alive = 1;
    scen = "R9 local";
    rate_check("R9");

    scen = "R6";
    wr(16'h0000);
    ticks(30);
    scen = "R10";
    wr(16'hFFFE);
    ticks(30);

    scen = "R8";
    wr(16'h0001);
    ticks(2);
    wr(16'h0000);
    ticks(DLY + MID);
    wr(16'h0000);
    ticks(30);
    chk(stat_local == 1'b0, "R5", int'(stat_local), 0);

    scen = "R9 bus";
    rate_check("R9");

    scen = "R6 bus";
    wr(16'h0001);
    ticks(30);

    scen = "R11";
    bus_run = 1'b0;
    ticks(40);
    m_alive = 0;
    wr(16'h0000);
    ticks(30);
    chk(stat_local == 1'b1, "R11", int'(stat_local), 1);

    scen = "R7";
    wr(16'h0001);
    ticks(30);
    chk(stat_local == 1'b1, "R7", int'(stat_local), 1);

    scen = "R10 bus";
    bus_run = 1'b1;
    ticks(40);
    m_alive = 1;
    wr(16'h0003);
    ticks(30);
    chk(stat_local == 1'b0, "R10", int'(stat_local), 0);
    scen = "R2 back";
    wr(16'h0000);
    ticks(30);
    rate_check("R9");

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule